// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a direct-mapped data cache. It sits between a pipelined processor and a slower block-oriented memory. The processor presents a word address with a read or write request. A request that hits completes in the same cycle. A request that misses raises a stall, and the stall stays up until the line has been brought in and the access has been served. Each line keeps a valid bit, a dirty bit and a tag.

Writes use write-back with write-allocate. A write hit changes only the cached copy and marks the line dirty. A write miss first fetches the block and then applies the word. When a line is replaced, a dirty victim is written back to memory as a whole block before the refill read is issued. A clean victim is dropped without any memory traffic.

The memory side is a held request with a one-cycle acknowledge. Each transaction moves one full block.

Top module: `dm_wb_cache`

## Requirements
- R1: `addr_i` is a word address. Bits [1:0] select the word within the block, bits [4:2] select one of 8 lines, and bits [11:5] form the tag.
- R2: A request hits only when the selected line is valid and its stored tag equals the address tag. A hit completes with `stall_o` low and issues no memory request. A read hit returns the word on `rdata_o` in the same cycle.
- R3: After reset every line is invalid and clean. The first access to any line misses, and evicting a line that was filled after reset without being written produces no write-back.
- R4: A memory transaction moves one block of four 32-bit words. `mem_addr_o` is the block address (address bits [11:2]). Word i of the block sits at bits [32*i+31:32*i] of `mem_wdata_o` and `mem_rdata_i`.
- R5: A write hit updates only the cached word and issues no memory transaction. A later read returns the new value.
- R6: When a dirty line is replaced, the whole block, including the words that were never written, goes to memory under the victim's block address. A clean victim causes no memory write.
- R7: A write miss reads the block from memory and then writes the word. The other three words of the block keep their memory values.
- R8: While a miss is being handled, `stall_o` stays high for as long as `req_i` is held. It drops only in the cycle in which the access completes.
- R9: On a miss to a dirty line, the write-back is acknowledged before the refill read is requested.
- R10: A line filled by a read miss is clean. A line filled by a write miss ends dirty.
- R11: `mem_req_o`, `mem_we_o` and `mem_addr_o` stay stable from the start of a request until `mem_ack_i`. No new request is issued in the cycle after the refill acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Processor access request, held while stalled |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 12 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid when req_i is high and stall_o is low |
| stall_o | output | 1 | Processor must hold its request |
| mem_req_o | output | 1 | Memory block request |
| mem_we_o | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr_o | output | 10 | Block address |
| mem_wdata_o | output | 128 | Block being written back |
| mem_rdata_i | input | 128 | Block returned by memory |
| mem_ack_i | input | 1 | One-cycle completion of the memory request |

## Verification
The hardest case to reach is a miss to a dirty line. The stimulus has to fill a line, dirty it through a write hit, and then read a different tag that maps to the same index. Only then does the back-to-back write-back and refill appear, and only then can the order of the two be seen. The bench uses a memory model that logs every transaction in order, and it checks the written-back block word by word. A write miss is then followed by a second conflicting read, which shows that the allocated line came out dirty. A read refill is followed by a conflict, which shows that a read-filled line comes out clean.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WBACK = 2'd1,
    ST_FILL  = 2'd2
  } miss_st_e;
endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 7,
  localparam int LINES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             fill_i,
  input  logic             mark_dirty_i,
  output logic             hit_o,
  output logic             vic_dirty_o,
  output logic [TAG_W-1:0] vic_tag_o
);
  logic [LINES-1:0] vld_q, dty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      dty_q <= '0;
    end else if (fill_i) begin
      vld_q[idx_i] <= 1'b1;
      dty_q[idx_i] <= 1'b0;
    end else if (mark_dirty_i) begin
      dty_q[idx_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i) tag_q[idx_i] <= tag_i;
  end

  assign hit_o       = vld_q[idx_i] && (tag_q[idx_i] == tag_i);
  assign vic_dirty_o = vld_q[idx_i] && dty_q[idx_i];
  assign vic_tag_o   = tag_q[idx_i];

  // R10
  fill_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i |=> vld_q[$past(idx_i)] && !dty_q[$past(idx_i)]);
  // R10
  mark_dirty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mark_dirty_i && !fill_i) |=> dty_q[$past(idx_i)]);
endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int WORD_W = 32,
  localparam int LINES = 1 << IDX_W,
  localparam int BLK_W = WORD_W << OFF_W
) (
  input  logic              clk_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              line_we_i,
  input  logic [BLK_W-1:0]  line_i,
  input  logic              word_we_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] word_o,
  output logic [BLK_W-1:0]  line_o
);
  logic [BLK_W-1:0] blk_q [LINES];

  always_ff @(posedge clk_i) begin
    if (line_we_i)      blk_q[idx_i] <= line_i;
    else if (word_we_i) blk_q[idx_i][off_i*WORD_W +: WORD_W] <= word_i;
  end

  assign line_o = blk_q[idx_i];
  assign word_o = line_o[off_i*WORD_W +: WORD_W];
endmodule

// File: rtl/cache_miss_fsm.sv
module cache_miss_fsm
  import cache_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic hit_i,
  input  logic vic_dirty_i,
  input  logic mem_ack_i,
  output logic busy_o,
  output logic mem_req_o,
  output logic mem_we_o,
  output logic fill_o
);
  miss_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_i && !hit_i) st_d = vic_dirty_i ? ST_WBACK : ST_FILL;
      ST_WBACK: if (mem_ack_i) st_d = ST_FILL;
      ST_FILL:  if (mem_ack_i) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign mem_req_o = busy_o;
  assign mem_we_o  = (st_q == ST_WBACK);
  assign fill_o    = (st_q == ST_FILL) && mem_ack_i;

  // R8
  miss_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i && !hit_i) |=> busy_o);
endmodule

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3,
  parameter int OFF_W  = 2,
  parameter int WORD_W = 32,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W,
  localparam int BLK_W = WORD_W << OFF_W,
  localparam int BA_W  = ADDR_W - OFF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              stall_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [BA_W-1:0]   mem_addr_o,
  output logic [BLK_W-1:0]  mem_wdata_o,
  input  logic [BLK_W-1:0]  mem_rdata_i,
  input  logic              mem_ack_i
);
  logic [OFF_W-1:0] off;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag, vic_tag;
  logic hit, vic_dirty, busy, fill, word_we;

  assign off = addr_i[OFF_W-1:0];
  assign idx = addr_i[OFF_W +: IDX_W];
  assign tag = addr_i[ADDR_W-1 -: TAG_W];

  assign word_we = req_i && we_i && hit && !busy;
  assign stall_o = req_i && (busy || !hit);

  cache_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk_i, .rst_ni, .idx_i(idx), .tag_i(tag), .fill_i(fill),
    .mark_dirty_i(word_we), .hit_o(hit), .vic_dirty_o(vic_dirty),
    .vic_tag_o(vic_tag)
  );

  cache_data_store #(.IDX_W(IDX_W), .OFF_W(OFF_W), .WORD_W(WORD_W)) u_data (
    .clk_i, .idx_i(idx), .off_i(off), .line_we_i(fill), .line_i(mem_rdata_i),
    .word_we_i(word_we), .word_i(wdata_i), .word_o(rdata_o), .line_o(mem_wdata_o)
  );

  cache_miss_fsm u_fsm (
    .clk_i, .rst_ni, .req_i, .hit_i(hit), .vic_dirty_i(vic_dirty),
    .mem_ack_i, .busy_o(busy), .mem_req_o, .mem_we_o, .fill_o(fill)
  );

  assign mem_addr_o = mem_we_o ? {vic_tag, idx} : {tag, idx};

  // R11
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o));
  // R9
  wb_then_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_ack_i) |=> mem_req_o && !mem_we_o);
  // R11
  fill_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> !mem_req_o);
  // R5
  hit_no_mem_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !stall_o) |-> !mem_req_o);
  // R8
  stall_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && mem_req_o) |-> stall_o);
endmodule

// File: tb/tb_dm_wb_cache.sv
module tb_dm_wb_cache;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic stall, mem_req, mem_we, mem_ack = 1'b0;
  logic [9:0] mem_addr;
  logic [127:0] mem_wdata, mem_rdata = '0;

  always #2ns clk = ~clk;

  dm_wb_cache dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .stall_o(stall), .mem_req_o(mem_req),
    .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  int n_chk = 0, n_bad = 0;
  int n_rd = 0, n_wr = 0, n_tx = 0;
  logic tx_we [64];
  logic [9:0] last_addr;
  logic [127:0] bmem [1024];
  int lat = 0;

  function automatic logic [31:0] pat(input logic [11:0] a);
    return {4'h5, a, 4'hA, ~a};
  endfunction

  // memory model: acknowledges after a short wait, logs order (R4, R9)
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req) begin
      if (lat == 2) begin
        lat = 0;
        mem_ack = 1'b1;
        last_addr = mem_addr;
        if (n_tx < 64) tx_we[n_tx] = mem_we;
        n_tx++;
        if (mem_we) begin bmem[mem_addr] = mem_wdata; n_wr++; end
        else begin mem_rdata = bmem[mem_addr]; n_rd++; end
      end else lat++;
    end
  end

  task automatic chk(input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d,
                     output logic [31:0] q, output int st);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; st = 0;
    #1;
    while (stall) begin st++; @(negedge clk); #1; end
    q = rdata;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  localparam logic [11:0] A = 12'h024, C = 12'h0A4, D = 12'h048, E = 12'h148;
  logic [31:0] q;
  int st, r0, w0, t0;

  task automatic t_reset();
    @(negedge clk);
    chk("R3 stall idle", stall, 0);
    chk("R3 mem idle", mem_req, 0);
  endtask

  task automatic t_read_miss();
    r0 = n_rd; w0 = n_wr;
    acc(0, A, 0, q, st);
    chk("R2 miss data", q, pat(A));
    chk("R3 cold miss read", n_rd - r0, 1);
    chk("R3 cold no wb", n_wr - w0, 0);
    chk("R8 stalled", st > 0, 1);
    chk("R4 block addr", last_addr, A[11:2]);
  endtask

  task automatic t_read_hit();
    r0 = n_rd;
    acc(0, A + 12'd1, 0, q, st);
    chk("R1 word select", q, pat(A + 12'd1));
    chk("R2 hit no stall", st, 0);
    chk("R2 hit no mem", n_rd - r0, 0);
    acc(0, A + 12'd3, 0, q, st);
    chk("R1 last word", q, pat(A + 12'd3));
  endtask

  task automatic t_write_hit();
    r0 = n_rd; w0 = n_wr;
    acc(1, A, 32'hDEAD_0001, q, st);
    chk("R5 write hit stall", st, 0);
    chk("R5 no mem tx", (n_rd - r0) + (n_wr - w0), 0);
    acc(0, A, 0, q, st);
    chk("R5 readback", q, 32'hDEAD_0001);
  endtask

  task automatic t_dirty_evict();
    r0 = n_rd; w0 = n_wr; t0 = n_tx;
    acc(0, C, 0, q, st);
    chk("R6 conflict data", q, pat(C));
    chk("R6 one wb", n_wr - w0, 1);
    chk("R6 one fill", n_rd - r0, 1);
    chk("R9 wb first", tx_we[t0], 1);
    chk("R9 fill second", tx_we[t0+1], 0);
    chk("R6 wb word0", bmem[A[11:2]][31:0], 32'hDEAD_0001);
    chk("R6 wb word1", bmem[A[11:2]][63:32], pat(A + 12'd1));
    chk("R4 wb word3", bmem[A[11:2]][127:96], pat(A + 12'd3));
  endtask

  task automatic t_clean_evict();
    w0 = n_wr;
    acc(0, A, 0, q, st);
    chk("R6 refetch written", q, 32'hDEAD_0001);
    chk("R10 read fill clean", n_wr - w0, 0);
    acc(0, C, 0, q, st);
    chk("R10 clean victim no wb", n_wr - w0, 0);
    chk("R6 data after clean evict", q, pat(C));
  endtask

  task automatic t_write_miss();
    r0 = n_rd; w0 = n_wr;
    acc(1, D, 32'hBEEF_0002, q, st);
    chk("R7 alloc read", n_rd - r0, 1);
    chk("R7 no wb", n_wr - w0, 0);
    chk("R8 write miss stalls", st > 0, 1);
    acc(0, D, 0, q, st);
    chk("R7 written word", q, 32'hBEEF_0002);
    acc(0, D + 12'd2, 0, q, st);
    chk("R7 neighbour word", q, pat(D + 12'd2));
    w0 = n_wr;
    acc(0, E, 0, q, st);
    chk("R10 write fill dirty", n_wr - w0, 1);
    chk("R10 wb content", bmem[D[11:2]][31:0], 32'hBEEF_0002);
    chk("R7 wb neighbour", bmem[D[11:2]][95:64], pat(D + 12'd2));
  endtask

  initial begin
    for (int b = 0; b < 1024; b++)
      for (int w = 0; w < 4; w++)
        bmem[b][32*w +: 32] = pat({b[9:0], w[1:0]});
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_read_miss();
    t_read_hit();
    t_write_hit();
    t_dirty_evict();
    t_clean_evict();
    t_write_miss();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule